// File: doc/BRIEF.md
# Shared-Bus Slave Request Encoder

This block sits on the secondary side of a bus that two transmitters share and that a primary arbiter controls. The primary sends a framed serial grant line that idles high. A falling edge on that line, after a long enough quiet stretch, marks the start of a frame. The block counts cycles from that edge. Each local queue owns one request slot in the frame, and in that slot the block pulls its request line low for one cycle if the queue has a cell waiting.

The same grant line carries a short serial header after the start bit: a queue number sent MSB first, an active-low valid flag and a reserved bit. The block decodes this header. When the grant is valid it reports the queue number with a one-cycle strobe and holds a busy flag for the fixed transmit window of one cell. A configuration input sets the window length. Cell storage, the data path and output-enable control sit outside this block.

Top module: `shrbus_slave_req`

## Requirements
- R1: During and right after reset, `req_out` is 1 and `grant_vld`, `tx_busy` and `frame_err` are 0.
- R2: A start of grant is a cycle in which `grant_in` is 0, the previous cycle was 1, the line was 1 for at least 6 consecutive cycles before it, and the cycle is not a header bit of the current frame. That cycle is frame offset 0, and each later cycle raises the offset by one.
- R3: At frame offset 10+n, for n from 0 to 31, `req_out` is 0 for exactly that cycle when `q_pending[n]` is 1 in that cycle, and 1 otherwise.
- R4: `req_out` is 1 at every cycle that is not inside a request slot (offsets 10 to 41 of a live frame), whatever `q_pending` holds.
- R5: `q_pending[n]` is looked at only in the slot cycle of queue n. Changes in other cycles have no effect on `req_out`.
- R6: Header bits sit at fixed offsets: queue number bit 4 at offset 1 down to bit 0 at offset 5, the valid flag at offset 6 (0 = valid) and a reserved bit at offset 7 that is ignored. For a valid grant, `grant_vld` is 1 for exactly one cycle, at offset 7, and `grant_q` carries the decoded queue number in that cycle.
- R7: When the valid flag at offset 6 is 1, `grant_vld` stays 0 and no transmit window opens.
- R8: A valid grant raises `tx_busy` in the cycle that `grant_vld` is high and keeps it high for 55 cycles if `win_long` was 1 at offset 6, or for 53 cycles if it was 0. A later valid grant restarts the window.
- R9: A falling edge on `grant_in` outside the header, with fewer than 6 high cycles before it, sets `frame_err` to 1 for one cycle, in the cycle after the low. It does not start a frame, and a frame already running keeps its offset count.
- R10: Low bits in the header (offsets 1 to 7) are data. They never start a frame and never raise `frame_err`.
- R11: A start of grant that arrives while an earlier frame is still counting (after its header) restarts the offset at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grant_in | input | 1 | Serial grant line from the primary, idle high |
| q_pending | input | NUM_Q | One bit per local queue, 1 when the queue holds a cell |
| win_long | input | 1 | Transmit window select: 1 = 55 cycles, 0 = 53 cycles |
| req_out | output | 1 | Serial request line, low in a queue's slot when it has a cell |
| grant_vld | output | 1 | One-cycle strobe for a decoded valid grant |
| grant_q | output | QW | Queue number of the last valid grant |
| tx_busy | output | 1 | High for the whole transmit window |
| frame_err | output | 1 | One-cycle flag for a start edge that came too early |

## Verification
The bench follows the frame offset with its own counter and predicts the request line from the pending bits it drives. A design whose slot is one cycle off, that samples a queue early, or that pulls the line low outside the slots fails at once, because the pending bits change at random every cycle. Frames that are cut short and restarted after the header show whether the offset really resets; an early low after a cut-short frame shows whether a too-short idle is flagged without disturbing the frame that is still running. Queue numbers at both ends of the range, random reserved bits, invalid grants, and a random window select at the valid-flag cycle find bit-order errors, a strobe on an invalid grant, and a window that is one cycle short or long.

// File: rtl/shrbus_pkg.sv
package shrbus_pkg;

  // Transmit window length picked by the mode bit.
  function automatic int unsigned win_len(input logic long_m,
                                          input int unsigned short_w,
                                          input int unsigned long_w);
    return long_m ? long_w : short_w;
  endfunction

  // True when v lies within [lo, hi].
  function automatic logic in_window(input int unsigned v,
                                     input int unsigned lo,
                                     input int unsigned hi);
    return (v >= lo) && (v <= hi);
  endfunction

  // Offset of a queue's request slot inside a frame.
  function automatic int unsigned slot_offset(input int unsigned base,
                                              input int unsigned qn);
    return base + qn;
  endfunction

endpackage

// File: rtl/sbs_sog_detect.sv
module sbs_sog_detect #(
  parameter int unsigned MIN_IDLE = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gin,
  input  logic hdr_busy,
  output logic sog,
  output logic err
);
  localparam int unsigned IDW = $clog2(MIN_IDLE + 1);
  localparam logic [IDW-1:0] IDLE_SAT = IDW'(MIN_IDLE);

  logic [IDW-1:0] idle_cnt;
  logic           gin_q;
  logic           fall_seen;

  // A falling edge that is not part of a frame header.
  assign fall_seen = !gin && gin_q && !hdr_busy;
  assign sog       = fall_seen && (idle_cnt >= IDLE_SAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_cnt <= '0;
      gin_q    <= 1'b1;
      err      <= 1'b0;
    end else begin
      gin_q <= gin;
      err   <= fall_seen && (idle_cnt < IDLE_SAT);
      if (!gin)
        idle_cnt <= '0;
      else if (idle_cnt != IDLE_SAT)
        idle_cnt <= idle_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sbs_frame_ctr.sv
module sbs_frame_ctr #(
  parameter int unsigned OFFW     = 6,
  parameter int unsigned LAST_OFF = 41
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sog,
  output logic [OFFW-1:0] off
);
  localparam logic [OFFW-1:0] LAST_O = OFFW'(LAST_OFF);

  // off == 0 means no frame is running; otherwise it is the offset
  // of the current cycle from the start of grant.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      off <= '0;
    else if (sog)
      off <= OFFW'(1);
    else if (off != '0)
      off <= (off == LAST_O) ? '0 : off + 1'b1;
  end
endmodule

// File: rtl/sbs_grant_deser.sv
module sbs_grant_deser #(
  parameter int unsigned QW   = 5,
  parameter int unsigned OFFW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OFFW-1:0] off,
  input  logic            gin,
  output logic            grant_hit,
  output logic            vld,
  output logic [QW-1:0]   q
);
  localparam logic [OFFW-1:0] LAST_QBIT = OFFW'(QW);
  localparam logic [OFFW-1:0] VLD_O     = OFFW'(QW + 1);

  logic [QW-1:0] shreg;
  logic          qbit_phase;

  assign qbit_phase = (off != '0) && (off <= LAST_QBIT);
  assign grant_hit  = (off == VLD_O) && !gin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      vld   <= 1'b0;
      q     <= '0;
    end else begin
      if (qbit_phase)
        shreg <= {shreg[QW-2:0], gin};
      vld <= grant_hit;
      if (grant_hit)
        q <= shreg;
    end
  end
endmodule

// File: rtl/sbs_tx_window.sv
module sbs_tx_window
  import shrbus_pkg::*;
#(
  parameter int unsigned SHORT_W = 53,
  parameter int unsigned LONG_W  = 55
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic long_m,
  output logic busy
);
  localparam int unsigned CW = $clog2(LONG_W + 1);

  logic [CW-1:0] cnt;

  assign busy = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (load)
      cnt <= CW'(win_len(long_m, SHORT_W, LONG_W));
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/shrbus_slave_req.sv
module shrbus_slave_req
  import shrbus_pkg::*;
#(
  parameter int unsigned NUM_Q    = 32,
  parameter int unsigned QW       = $clog2(NUM_Q),
  parameter int unsigned REQ_BASE = 10,
  parameter int unsigned MIN_IDLE = 6,
  parameter int unsigned SHORT_W  = 53,
  parameter int unsigned LONG_W   = 55
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grant_in,
  input  logic [NUM_Q-1:0] q_pending,
  input  logic             win_long,
  output logic             req_out,
  output logic             grant_vld,
  output logic [QW-1:0]    grant_q,
  output logic             tx_busy,
  output logic             frame_err
);
  localparam int unsigned HDR_LEN  = QW + 3;
  localparam int unsigned LAST_OFF = REQ_BASE + NUM_Q - 1;
  localparam int unsigned OFFW     = $clog2(LAST_OFF + 1);
  localparam logic [OFFW-1:0] HDR_O  = OFFW'(HDR_LEN);
  localparam logic [OFFW-1:0] BASE_O = OFFW'(REQ_BASE);

  // Named internal events, also used by the checker.
  logic            sog_evt;
  logic            frame_act;
  logic            hdr_busy;
  logic            grant_hit;
  logic            slot_act;
  logic [OFFW-1:0] frame_off;
  logic [QW-1:0]   slot_idx;

  assign frame_act = (frame_off != '0);
  assign hdr_busy  = frame_act && (frame_off < HDR_O);
  assign slot_act  = frame_act &&
                     in_window(32'(frame_off), REQ_BASE, LAST_OFF);
  assign slot_idx  = QW'(frame_off - BASE_O);

  sbs_sog_detect #(.MIN_IDLE(MIN_IDLE)) u_sog (
    .clk      (clk),
    .rst_n    (rst_n),
    .gin      (grant_in),
    .hdr_busy (hdr_busy),
    .sog      (sog_evt),
    .err      (frame_err)
  );

  sbs_frame_ctr #(.OFFW(OFFW), .LAST_OFF(LAST_OFF)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .sog   (sog_evt),
    .off   (frame_off)
  );

  sbs_grant_deser #(.QW(QW), .OFFW(OFFW)) u_deser (
    .clk       (clk),
    .rst_n     (rst_n),
    .off       (frame_off),
    .gin       (grant_in),
    .grant_hit (grant_hit),
    .vld       (grant_vld),
    .q         (grant_q)
  );

  sbs_tx_window #(.SHORT_W(SHORT_W), .LONG_W(LONG_W)) u_win (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (grant_hit),
    .long_m (win_long),
    .busy   (tx_busy)
  );

  // The pending bit of a queue is looked at only in its own slot.
  assign req_out = !(slot_act && q_pending[slot_idx]);
endmodule

// File: rtl/sbs_checker.sv
module sbs_checker (
  input logic clk,
  input logic rst_n,
  input logic req_out,
  input logic grant_vld,
  input logic tx_busy,
  input logic frame_err,
  input logic sog_evt,
  input logic frame_act,
  input logic hdr_busy
);
  // R2
  sog_starts_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sog_evt |=> frame_act);

  // R4
  req_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_out |-> frame_act);

  // R6
  vld_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld |=> !grant_vld);

  // R8
  busy_with_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld |-> tx_busy);

  // R8
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> grant_vld);

  // R9
  sog_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sog_evt |=> !frame_err);

  // R10
  hdr_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_busy |=> !frame_err);
endmodule

bind shrbus_slave_req sbs_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_out   (req_out),
  .grant_vld (grant_vld),
  .tx_busy   (tx_busy),
  .frame_err (frame_err),
  .sog_evt   (sog_evt),
  .frame_act (frame_act),
  .hdr_busy  (hdr_busy)
);

// File: tb/test_shrbus_slave_req.sv
module test_shrbus_slave_req;
  logic        clk;
  logic        rst_n;
  logic        grant_in;
  logic [31:0] q_pending;
  logic        win_long;
  logic        req_out;
  logic        grant_vld;
  logic [4:0]  grant_q;
  logic        tx_busy;
  logic        frame_err;

  int checks = 0;
  int fails  = 0;
  int boff   = 0;   // bench view of the frame offset in the current step
  int busy_left = 0;

  shrbus_slave_req i_shrbus_slave_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .grant_in  (grant_in),
    .q_pending (q_pending),
    .win_long  (win_long),
    .req_out   (req_out),
    .grant_vld (grant_vld),
    .grant_q   (grant_q),
    .tx_busy   (tx_busy),
    .frame_err (frame_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int exp_win(input logic lm);
    return lm ? 55 : 53;
  endfunction

  function automatic logic exp_req_of(input int o, input logic [31:0] pend);
    if (o >= 10 && o <= 41) return ~pend[o-10];
    return 1'b1;
  endfunction

  task automatic step(input logic g, input logic [31:0] pend, input logic lm,
                      input bit is_sog, input logic e_vld, input logic [4:0] e_q,
                      input logic e_err, input string ctx);
    logic e_req;
    logic e_busy;
    bit   bad;
    @(negedge clk);
    grant_in = g; q_pending = pend; win_long = lm;
    #2;
    e_req  = exp_req_of(boff, pend);
    e_busy = (busy_left > 0);
    bad = 0;
    if (req_out !== e_req) begin
      bad = 1;
      $display("FAIL %s %s req_out off=%0d act=%b exp=%b",
               (boff >= 10 && boff <= 41) ? "R3" : "R4", ctx, boff, req_out, e_req);
    end
    if (grant_vld !== e_vld) begin
      bad = 1;
      $display("FAIL %s %s grant_vld act=%b exp=%b",
               e_vld ? "R6" : "R7", ctx, grant_vld, e_vld);
    end
    if (e_vld && grant_q !== e_q) begin
      bad = 1;
      $display("FAIL R6 %s grant_q act=%0d exp=%0d", ctx, grant_q, e_q);
    end
    if (tx_busy !== e_busy) begin
      bad = 1;
      $display("FAIL R8 %s tx_busy act=%b exp=%b", ctx, tx_busy, e_busy);
    end
    if (frame_err !== e_err) begin
      bad = 1;
      $display("FAIL %s %s frame_err act=%b exp=%b",
               e_err ? "R9" : "R10", ctx, frame_err, e_err);
    end
    checks++;
    if (bad) fails++;
    if (busy_left > 0) busy_left--;
    if (is_sog) boff = 1;
    else if (boff != 0) boff = (boff == 41) ? 0 : boff + 1;
  endtask

  task automatic idle(input int n, input string ctx);
    for (int i = 0; i < n; i++)
      step(1'b1, $urandom, 1'($urandom), 0, 1'b0, 5'd0, 1'b0, ctx);
  endtask

  // pmode: 0 random each cycle, 1 all zero, 2 all one
  task automatic frame(input logic [4:0] qn, input logic vbit, input int pmode,
                       input int len, input string ctx);
    logic        g;
    logic [31:0] pend;
    logic        lm;
    for (int o = 0; o < len; o++) begin
      if (o == 0)      g = 1'b0;
      else if (o <= 5) g = qn[5-o];
      else if (o == 6) g = vbit;
      else if (o == 7) g = 1'($urandom);
      else             g = 1'b1;
      pend = (pmode == 1) ? 32'h0 : (pmode == 2) ? 32'hFFFF_FFFF : $urandom;
      lm   = 1'($urandom);
      step(g, pend, lm, (o == 0), (o == 7) && !vbit, qn, 1'b0, ctx);
      if (o == 6 && !vbit) busy_left = exp_win(lm);
    end
  endtask

  initial begin
    #(1_000_000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; grant_in = 1'b1; q_pending = '1; win_long = 1'b0;
    repeat (3) @(negedge clk);
    #2;
    checks++;
    if (req_out !== 1'b1 || grant_vld !== 1'b0 || tx_busy !== 1'b0 || frame_err !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset outputs act=%b%b%b%b exp=1000",
               req_out, grant_vld, tx_busy, frame_err);
    end
    @(negedge clk); rst_n = 1'b1;
    idle(2, "R1 after reset");
    // R9: low after only a few idle cycles since reset
    step(1'b0, '1, 1'b0, 0, 1'b0, 5'd0, 1'b0, "R9 early low");
    step(1'b1, '1, 1'b0, 0, 1'b0, 5'd0, 1'b1, "R9 flag");
    idle(6, "R2 idle");
    // directed corners
    frame(5'd31, 1'b0, 2, 60, "R2 R3 all pending q31");
    frame(5'd0,  1'b0, 1, 60, "R4 R10 none pending q0");
    frame(5'd5,  1'b1, 2, 60, "R7 invalid");
    frame(5'd12, 1'b0, 0, 20, "R11 cut");
    frame(5'd17, 1'b0, 0, 60, "R11 restart");
    // R9 inside a running frame: too little idle after the header
    frame(5'd9, 1'b1, 0, 9, "R9 short");
    step(1'b0, $urandom, 1'b0, 0, 1'b0, 5'd0, 1'b0, "R9 mid-frame low");
    step(1'b1, $urandom, 1'b0, 0, 1'b0, 5'd0, 1'b1, "R9 mid-frame flag");
    idle(40, "R9 frame keeps count");
    // random frames; pending bits change every cycle (R5)
    for (int k = 0; k < 30; k++)
      frame(5'($urandom), 1'($urandom), 0, 14 + int'($urandom % 57), "R5 random");
    idle(70, "R8 drain");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule